// File: doc/BRIEF.md
# Replicated Multi-Read Byte Memory

This block is a byte-addressed memory that serves four independent reads in every clock cycle while taking one byte write per cycle. Each physical copy is one byte wide and holds the whole address space. Every write goes to every copy in the same cycle, so all copies always hold the same contents. Each read port has its own copies and can start at any byte address without any byte steering.

Two kinds of copy are used. A pair copy has two ports. It either reads two adjacent addresses or takes the write, but it cannot do both in one cycle. A single copy has one read port and one write port that work at the same time. A port that needs two or three bytes uses one pair copy for bytes A and A+1. A port that needs a third byte adds a single copy for A+2. A one-byte port uses only a single copy.

The four ports are:
- a 3-byte instruction fetch port,
- a 2-byte operand port,
- a 1-byte pointer port,
- a 3-byte stack port.

Any port that uses a pair copy reports its result as invalid for the cycle after a write.

Top module: `replicated_read_mem`

## Requirements
- R1: A byte written at address W is returned by every port that reads W in the cycle after the write. The write is seen by all copies.
- R2: Multi-byte data is packed with the lowest address in the low byte. For a port starting at A: bits [7:0] hold A, bits [15:8] hold A+1, and on 3-byte ports bits [23:16] hold A+2.
- R3: Every port accepts any byte address as its start, including addresses that are not multiples of 2 or 3.
- R4: When A+1 or A+2 runs past the top address, it wraps modulo the depth of 2^ADDR_W bytes.
- R5: Read data and valid flags appear exactly one clock after the address is presented.
- R6: In the cycle after a write cycle, the valid flags of the fetch, operand and stack ports are low.
- R7: The pointer port is never blocked by a write. Its valid flag is high in every cycle after the first clock out of reset.
- R8: A pointer-port read of the address being written in the same cycle returns the old byte.
- R9: While rst_n is low, all four valid flags are low.
- R10: In the cycle after a cycle with no write, all four valid flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears the valid flags |
| wrEn | input | 1 | Byte write enable |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write byte |
| codeAddr | input | ADDR_W | Fetch port start address |
| codeData | output | 24 | Fetch port bytes A+2, A+1, A (high to low) |
| codeValid | output | 1 | Fetch port data valid |
| dirAddr | input | ADDR_W | Operand port start address |
| dirData | output | 16 | Operand port bytes A+1, A |
| dirValid | output | 1 | Operand port data valid |
| indAddr | input | ADDR_W | Pointer port address |
| indData | output | 8 | Pointer port byte |
| indValid | output | 1 | Pointer port data valid |
| stkAddr | input | ADDR_W | Stack port start address |
| stkData | output | 24 | Stack port bytes A+2, A+1, A |
| stkValid | output | 1 | Stack port data valid |

## Verification
The bench fills a 64-byte configuration completely. It then reads every start address on all ports at once, using offsets that make the stack and fetch windows cross the top address. A design that dropped the wrap would return bytes from the wrong place near address 63. A design with a byte lane swapped would fail on almost every address.

A second pass writes while the pointer port reads the same address. This tests three things:
- A design that let the pair copies read during a write would raise a valid flag it cannot honour.
- A single copy with write-first behaviour would return the new byte instead of the old one.
- A write that reached only some copies would show stale data on the ports that read the address back in the next cycle.

// File: rtl/rmem_pkg.sv
package rmem_pkg;
  localparam int NUM_PORTS = 4;
  localparam int PORT_CODE = 0;
  localparam int PORT_DIR  = 1;
  localparam int PORT_IND  = 2;
  localparam int PORT_STK  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic write;     // broadcast write this cycle
    logic pairRead;  // pair copies may read this cycle
  } memStrobe_t;

  function automatic int portBytes(input int p);
    case (p)
      PORT_CODE: return 3;
      PORT_DIR:  return 2;
      PORT_IND:  return 1;
      default:   return 3;
    endcase
  endfunction
endpackage

// File: rtl/rmem_pair_copy.sv
// Two-port copy: either two reads or one write per cycle.
module rmem_pair_copy #(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  rmem_pkg::memStrobe_t st,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [7:0]           wrData,
  input  logic [ADDR_W-1:0]    addrA,
  input  logic [ADDR_W-1:0]    addrB,
  output logic [7:0]           qA,
  output logic [7:0]           qB
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (st.write) begin
      mem[wrAddr] <= wrData;
    end else if (st.pairRead) begin
      qA <= mem[addrA];
      qB <= mem[addrB];
    end
  end
endmodule

// File: rtl/rmem_single_copy.sv
// One read port plus one write port, both usable every cycle.
module rmem_single_copy #(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  rmem_pkg::memStrobe_t st,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [7:0]           wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [7:0]           q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (st.write) mem[wrAddr] <= wrData;
    q <= mem[rdAddr];  // old data on a same-address write
  end
endmodule

// File: rtl/rmem_ctrl.sv
module rmem_ctrl
  import rmem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] baseAddr  [NUM_PORTS],
  output memStrobe_t        st,
  output logic [ADDR_W-1:0] addrPlus1 [NUM_PORTS],
  output logic [ADDR_W-1:0] addrPlus2 [NUM_PORTS],
  output logic              portValid [NUM_PORTS]
);
  always_comb begin
    st.write    = wrEn;
    st.pairRead = !wrEn;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    // ADDR_W-bit sums wrap modulo the depth
    assign addrPlus1[p] = baseAddr[p] + ADDR_W'(1);
    assign addrPlus2[p] = baseAddr[p] + ADDR_W'(2);

    if (portBytes(p) >= 2) begin : gBlockable
      always_ff @(posedge clk) begin
        if (!rst_n) portValid[p] <= 1'b0;
        else        portValid[p] <= st.pairRead;
      end
    end else begin : gFree
      always_ff @(posedge clk) begin
        if (!rst_n) portValid[p] <= 1'b0;
        else        portValid[p] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmem_datapath.sv
module rmem_datapath
  import rmem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  memStrobe_t        st,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] addr0 [NUM_PORTS],
  input  logic [ADDR_W-1:0] addr1 [NUM_PORTS],
  input  logic [ADDR_W-1:0] addr2 [NUM_PORTS],
  output logic [23:0]       rdData [NUM_PORTS]
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    localparam int NB = portBytes(p);
    logic [7:0] b0, b1, b2;

    if (NB >= 2) begin : gPair
      rmem_pair_copy #(.ADDR_W(ADDR_W)) uPair (
        .clk(clk), .st(st), .wrAddr(wrAddr), .wrData(wrData),
        .addrA(addr0[p]), .addrB(addr1[p]), .qA(b0), .qB(b1));
    end else begin : gLow
      rmem_single_copy #(.ADDR_W(ADDR_W)) uLow (
        .clk(clk), .st(st), .wrAddr(wrAddr), .wrData(wrData),
        .rdAddr(addr0[p]), .q(b0));
      assign b1 = 8'h00;
    end

    if (NB == 3) begin : gTop
      rmem_single_copy #(.ADDR_W(ADDR_W)) uTop (
        .clk(clk), .st(st), .wrAddr(wrAddr), .wrData(wrData),
        .rdAddr(addr2[p]), .q(b2));
    end else begin : gNoTop
      assign b2 = 8'h00;
    end

    assign rdData[p] = {b2, b1, b0};
  end
endmodule

// File: rtl/replicated_read_mem.sv
module replicated_read_mem
  import rmem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] codeAddr,
  output logic [23:0]       codeData,
  output logic              codeValid,
  input  logic [ADDR_W-1:0] dirAddr,
  output logic [15:0]       dirData,
  output logic              dirValid,
  input  logic [ADDR_W-1:0] indAddr,
  output logic [7:0]        indData,
  output logic              indValid,
  input  logic [ADDR_W-1:0] stkAddr,
  output logic [23:0]       stkData,
  output logic              stkValid
);
  memStrobe_t        st;
  logic [ADDR_W-1:0] baseAddr  [NUM_PORTS];
  logic [ADDR_W-1:0] addrPlus1 [NUM_PORTS];
  logic [ADDR_W-1:0] addrPlus2 [NUM_PORTS];
  logic              portValid [NUM_PORTS];
  logic [23:0]       rdData    [NUM_PORTS];

  assign baseAddr[PORT_CODE] = codeAddr;
  assign baseAddr[PORT_DIR]  = dirAddr;
  assign baseAddr[PORT_IND]  = indAddr;
  assign baseAddr[PORT_STK]  = stkAddr;

  rmem_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .baseAddr(baseAddr),
    .st(st), .addrPlus1(addrPlus1), .addrPlus2(addrPlus2),
    .portValid(portValid));

  rmem_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .st(st), .wrAddr(wrAddr), .wrData(wrData),
    .addr0(baseAddr), .addr1(addrPlus1), .addr2(addrPlus2),
    .rdData(rdData));

  assign codeData  = rdData[PORT_CODE];
  assign dirData   = rdData[PORT_DIR][15:0];
  assign indData   = rdData[PORT_IND][7:0];
  assign stkData   = rdData[PORT_STK];
  assign codeValid = portValid[PORT_CODE];
  assign dirValid  = portValid[PORT_DIR];
  assign indValid  = portValid[PORT_IND];
  assign stkValid  = portValid[PORT_STK];
endmodule

// File: rtl/rmem_checker.sv
module rmem_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [ADDR_W-1:0] indAddr,
  input logic [7:0]        indData,
  input logic              indValid,
  input logic              codeValid,
  input logic              dirValid,
  input logic              stkValid
);
  assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (!codeValid && !dirValid && !stkValid));

  assert_unblocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> (codeValid && dirValid && stkValid && indValid));

  assert_pointer_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> indValid);

  // read of an address in the cycle after it was written returns the new byte
  assert_broadcast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrEn) && indAddr == $past(wrAddr)) |=> indData == $past(wrData, 2));
endmodule

bind replicated_read_mem rmem_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .indAddr(indAddr), .indData(indData), .indValid(indValid),
  .codeValid(codeValid), .dirValid(dirValid), .stkValid(stkValid));

// File: tb/tb_replicated_read_mem.sv
`timescale 1ns/1ps
module tb_replicated_read_mem;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [AW-1:0] codeAddr = '0, dirAddr = '0, indAddr = '0, stkAddr = '0;
  logic [23:0] codeData, stkData;
  logic [15:0] dirData;
  logic [7:0] indData;
  logic codeValid, dirValid, indValid, stkValid;

  int total = 0;
  int failed = 0;
  bit finished = 0;
  logic [7:0] refMem [DEPTH];

  always #4 clk = ~clk;

  replicated_read_mem #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .codeAddr(codeAddr), .codeData(codeData), .codeValid(codeValid),
    .dirAddr(dirAddr), .dirData(dirData), .dirValid(dirValid),
    .indAddr(indAddr), .indData(indData), .indValid(indValid),
    .stkAddr(stkAddr), .stkData(stkData), .stkValid(stkValid));

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] win3(input logic [AW-1:0] a);
    logic [AW-1:0] a1 = a + AW'(1);
    logic [AW-1:0] a2 = a + AW'(2);
    return {refMem[a2], refMem[a1], refMem[a]};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: flags low during reset
    check("R9 reset valid", {20'h0, codeValid, dirValid, indValid, stkValid}, 24'h0);
    rst_n = 1'b1;
    // fill every address
    for (int a = 0; a < DEPTH; a++) begin
      refMem[a] = 8'((a * 37 + 5) & 8'hff);
      wrEn = 1'b1; wrAddr = AW'(a); wrData = refMem[a];
      @(negedge clk);
    end
    wrEn = 1'b0;
    // full sweep: any start address, lane order, wrap, one-cycle latency
    for (int a = 0; a < DEPTH; a++) begin
      codeAddr = AW'(a); dirAddr = AW'(a + 7);
      indAddr = AW'(a + 13); stkAddr = AW'(a + 62);
      @(negedge clk);
      check("R2 R3 code", codeData, win3(codeAddr));
      check("R2 dir", {8'h0, dirData}, {8'h0, win3(dirAddr)[15:0]});
      check("R5 ind", {16'h0, indData}, {16'h0, refMem[indAddr]});
      check("R4 stk wrap", stkData, win3(stkAddr));
      check("R10 valid", {20'h0, codeValid, dirValid, indValid, stkValid}, 24'hf);
    end
    // writes colliding with reads
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] w;
      logic [7:0] nv;
      logic [7:0] oldv;
      w = AW'(k * 5 + 3);
      nv = 8'(8'hA0 ^ k);
      oldv = refMem[w];
      wrEn = 1'b1; wrAddr = w; wrData = nv;
      indAddr = w; codeAddr = w; dirAddr = w; stkAddr = w;
      @(negedge clk);
      check("R6 blocked", {21'h0, codeValid, dirValid, stkValid}, 24'h0);
      check("R7 ind valid", {23'h0, indValid}, 24'h1);
      check("R8 old data", {16'h0, indData}, {16'h0, oldv});
      refMem[w] = nv;
      wrEn = 1'b0;
      codeAddr = w; dirAddr = w - AW'(1); stkAddr = w - AW'(2); indAddr = w;
      @(negedge clk);
      check("R1 code", codeData, win3(codeAddr));
      check("R1 dir", {8'h0, dirData}, {8'h0, win3(dirAddr)[15:0]});
      check("R1 stk", stkData, win3(stkAddr));
      check("R1 ind", {16'h0, indData}, {16'h0, nv});
      check("R10 valid after", {20'h0, codeValid, dirValid, indValid, stkValid}, 24'hf);
    end
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end
endmodule